// File: doc/BRIEF.md
# System Control Register Block

This block is a word-addressed register file that sits on a simple 32-bit register bus. It has one address, a write strobe with write data, and a read strobe with registered read data. It decodes a 4 KiB byte-addressed window into 1024 storage words. Most words are plain storage. A few of them carry side effects that the rest of the chip relies on.

One word is the command word. Writing certain values to it produces single-cycle request pulses toward the system reset and power logic. Three identification words always return two fixed status bits when read. Those bits are never written into storage. Four words at the start of the identification area load nonzero values on reset, and every other word clears.

Reset is asynchronous and active-low. Its release is synchronised inside the block. The surrounding chip decides what to do with the request pulses. This block only raises them.

Top module: `sysctl_regs`

## Requirements
- R1: After reset, reads return these values:
  - byte offset 0x100 returns 0x35F20121 (stored value 0x05F20121 with the status bits added).
  - byte offset 0x104 returns 0x00000002.
  - byte offset 0x108 returns 0x35F30121.
  - byte offset 0x10C returns 0x35F40121.
  - every other in-window word returns 0.
- R2: A write stores the 32-bit write data into the word selected by address bits 11:2. A later read of that word returns the stored data. Read data appears on `rd_data` in the cycle after the read strobe is sampled.
- R3: Writing 1 or 2 to byte offset 0xF00 drives `reset_req` high for exactly one cycle, in the cycle after the write is sampled.
- R4: Writing 3 to byte offset 0xF00 drives `shutdown_req` high for exactly one cycle, in the cycle after the write is sampled.
- R5: Writing any other value to byte offset 0xF00 raises neither request. Every write to 0xF00 stores its data like any other word. The two requests are never high together.
- R6: A read of byte offset 0x100, 0x108 or 0x10C returns the stored word ORed with 0x30000000, so bits 29:28 always read 1. Reads of all other offsets, including 0x104, return the stored word unchanged.
- R7: When a read and a write hit the same word in the same cycle, the read returns the value held before that write.
- R8: Address bits 1:0 are ignored for both reads and writes.
- R9: An access whose address is 0x1000 or above is outside the window. Such a write changes no word and raises no request. Such a read returns 0.
- R10: While `rst_n` is low, `reset_req`, `shutdown_req` and `rd_data` are 0 and writes have no effect. Every word returns to its R1 value.
- R11: When the read strobe is low, `rd_data` holds its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | ADDR_W (16) | Byte address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| reset_req | output | 1 | One-cycle system reset request |
| shutdown_req | output | 1 | One-cycle system shutdown request |

## Verification
The command word is written with each of the values 0, 1, 2, 3 and 4. This separates the two reset codes from the shutdown code, and both from values that must stay silent. Every pulse is checked for width and for its absence a cycle later.

The identification words are overwritten with zero and read back. This separates forced bits from stored bits, with 0x104 serving as the neighbour that must not be forced.

Address patterns with nonzero low bits show that those bits are ignored. Addresses just past the window show that they are not decoded as aliases. A read and a write to one word in the same cycle show the ordering. A reset during a write attempt shows that no pulse leaks out.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  parameter int unsigned SC_DATA_W = 32;

  // Word indices (byte offset / 4) whose behaviour is special.
  localparam int unsigned SC_CMD_IDX  = 'h3C0;
  localparam int unsigned SC_ID0_IDX  = 'h040;
  localparam int unsigned SC_CFG_IDX  = 'h041;
  localparam int unsigned SC_ID1_IDX  = 'h042;
  localparam int unsigned SC_ID2_IDX  = 'h043;

  localparam logic [SC_DATA_W-1:0] SC_ID_FORCE = 32'h3000_0000;

  typedef enum logic [1:0] {
    SC_CMD_NONE     = 2'd0,
    SC_CMD_RESET    = 2'd1,
    SC_CMD_SHUTDOWN = 2'd2
  } sc_cmd_e;

  function automatic logic [SC_DATA_W-1:0] sc_reset_word(input int unsigned idx);
    case (idx)
      SC_ID0_IDX: return 32'h05F2_0121;
      SC_CFG_IDX: return 32'h0000_0002;
      SC_ID1_IDX: return 32'h05F3_0121;
      SC_ID2_IDX: return 32'h05F4_0121;
      default:    return '0;
    endcase
  endfunction

  function automatic sc_cmd_e sc_decode_cmd(input logic [SC_DATA_W-1:0] v);
    if (v == 32'd1 || v == 32'd2) return SC_CMD_RESET;
    if (v == 32'd3)               return SC_CMD_SHUTDOWN;
    return SC_CMD_NONE;
  endfunction

endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 4096,
  localparam int unsigned OFF_W    = $clog2(WIN_BYTES),
  localparam int unsigned IDX_W    = OFF_W - 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_range,
  output logic [IDX_W-1:0]  idx,
  output logic              is_cmd,
  output logic              is_id
);
  logic [1:0] unused_lsb;
  assign unused_lsb = addr[1:0];

  generate
    if (ADDR_W > OFF_W) begin : g_hi
      assign in_range = (addr[ADDR_W-1:OFF_W] == '0);
    end else begin : g_full
      assign in_range = 1'b1;
    end
  endgenerate

  assign idx = addr[OFF_W-1:2];

  always_comb begin
    is_cmd = in_range && (idx == IDX_W'(SC_CMD_IDX));
    is_id  = in_range && ((idx == IDX_W'(SC_ID0_IDX)) ||
                          (idx == IDX_W'(SC_ID1_IDX)) ||
                          (idx == IDX_W'(SC_ID2_IDX)));
  end
endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int unsigned WORDS  = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     widx,
  input  logic [SC_DATA_W-1:0] wdata,
  output logic [SC_DATA_W-1:0] words [WORDS]
);
  generate
    for (genvar i = 0; i < WORDS; i++) begin : g_word
      localparam logic [SC_DATA_W-1:0] RST_VAL = sc_reset_word(i);
      logic                 en;
      logic [SC_DATA_W-1:0] q;

      always_comb begin
        en = we && (widx == IDX_W'(i));
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= RST_VAL;
        else if (en) q <= wdata;
      end

      assign words[i] = q;
    end
  endgenerate
endmodule

// File: rtl/sysctl_cmd.sv
module sysctl_cmd
  import sysctl_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_fire,
  input  logic                 is_cmd,
  input  logic [SC_DATA_W-1:0] wdata,
  output logic                 reset_req,
  output logic                 shutdown_req
);
  sc_cmd_e cmd;
  logic    reset_d, shut_d;

  always_comb begin
    cmd     = (wr_fire && is_cmd) ? sc_decode_cmd(wdata) : SC_CMD_NONE;
    reset_d = (cmd == SC_CMD_RESET);
    shut_d  = (cmd == SC_CMD_SHUTDOWN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reset_req    <= 1'b0;
      shutdown_req <= 1'b0;
    end else begin
      reset_req    <= reset_d;
      shutdown_req <= shut_d;
    end
  end
endmodule

// File: rtl/sysctl_rdport.sv
module sysctl_rdport
  import sysctl_pkg::*;
#(
  parameter int unsigned WORDS  = 1024,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rd_en,
  input  logic                 in_range,
  input  logic                 is_id,
  input  logic [IDX_W-1:0]     ridx,
  input  logic [SC_DATA_W-1:0] words [WORDS],
  output logic [SC_DATA_W-1:0] rd_data
);
  logic [SC_DATA_W-1:0] sel, rd_d;

  always_comb begin
    sel  = in_range ? (words[ridx] | (is_id ? SC_ID_FORCE : '0)) : '0;
    rd_d = rd_en ? sel : rd_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_d;
  end
endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 4096,
  localparam int unsigned WORDS    = WIN_BYTES / 4,
  localparam int unsigned IDX_W    = $clog2(WORDS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr_en,
  input  logic [SC_DATA_W-1:0] wr_data,
  input  logic                 rd_en,
  output logic [SC_DATA_W-1:0] rd_data,
  output logic                 reset_req,
  output logic                 shutdown_req
);
  logic                 rst_sync_n;
  logic                 in_range, is_cmd, is_id, wr_fire;
  logic [IDX_W-1:0]     idx;
  logic [SC_DATA_W-1:0] words [WORDS];

  sysctl_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  sysctl_decode #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_dec (
    .addr(addr), .in_range(in_range), .idx(idx), .is_cmd(is_cmd), .is_id(is_id)
  );

  assign wr_fire = wr_en && in_range;

  sysctl_store #(.WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .we(wr_fire), .widx(idx),
    .wdata(wr_data), .words(words)
  );

  sysctl_cmd u_cmd (
    .clk(clk), .rst_n(rst_sync_n), .wr_fire(wr_fire), .is_cmd(is_cmd),
    .wdata(wr_data), .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  sysctl_rdport #(.WORDS(WORDS)) u_rd (
    .clk(clk), .rst_n(rst_sync_n), .rd_en(rd_en), .in_range(in_range),
    .is_id(is_id), .ridx(idx), .words(words), .rd_data(rd_data)
  );
endmodule

// File: rtl/sysctl_regs_chk.sv
module sysctl_regs_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned WIN_BYTES = 4096
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic              rd_en,
  input logic [31:0]       rd_data,
  input logic              reset_req,
  input logic              shutdown_req
);
  localparam logic [ADDR_W-1:0] CMD_OFF = ADDR_W'('hF00);
  localparam logic [ADDR_W-1:0] WIN     = ADDR_W'(WIN_BYTES);

  logic hit_cmd, oor, id_rd;
  always_comb begin
    hit_cmd = wr_en && ({addr[ADDR_W-1:2], 2'b00} == CMD_OFF);
    oor     = (addr >= WIN);
    id_rd   = rd_en && !oor &&
              ((addr[11:2] == 10'h040) || (addr[11:2] == 10'h042) || (addr[11:2] == 10'h043));
  end

  AST_RESET_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmd && (wr_data == 32'd1 || wr_data == 32'd2)) |=> reset_req); // R3
  AST_RESET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(hit_cmd && (wr_data == 32'd1 || wr_data == 32'd2))); // R3
  AST_SHUT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_cmd && wr_data == 32'd3) |=> shutdown_req); // R4
  AST_SHUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> $past(hit_cmd && wr_data == 32'd3)); // R4
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reset_req, shutdown_req})); // R5
  AST_ID_BITS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    id_rd |=> (rd_data[29:28] == 2'b11)); // R6
  AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && oor) |=> (rd_data == 32'd0)); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R11
endmodule

bind sysctl_regs sysctl_regs_chk #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_en(rd_en), .rd_data(rd_data), .reset_req(reset_req), .shutdown_req(shutdown_req)
);

// File: tb/sysctl_regs_test.sv
module sysctl_regs_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr;
  logic        wr_en, rd_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        reset_req, shutdown_req;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  sysctl_regs uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .reset_req(reset_req), .shutdown_req(shutdown_req)
  );

  // {is_read, req, addr, data (write data or expected read), exp reset, exp shutdown}
  localparam int NV = 26;
  localparam logic [54:0] VEC [NV] = '{
    {1'b1, 4'd1, 16'h0100, 32'h35F2_0121, 1'b0, 1'b0}, // R1
    {1'b1, 4'd1, 16'h0104, 32'h0000_0002, 1'b0, 1'b0}, // R1
    {1'b1, 4'd1, 16'h0108, 32'h35F3_0121, 1'b0, 1'b0}, // R1
    {1'b1, 4'd1, 16'h010C, 32'h35F4_0121, 1'b0, 1'b0}, // R1
    {1'b1, 4'd1, 16'h0200, 32'h0000_0000, 1'b0, 1'b0}, // R1
    {1'b0, 4'd2, 16'h0040, 32'hDEAD_BEEF, 1'b0, 1'b0}, // R2
    {1'b1, 4'd2, 16'h0040, 32'hDEAD_BEEF, 1'b0, 1'b0}, // R2
    {1'b0, 4'd3, 16'h0F00, 32'h0000_0001, 1'b1, 1'b0}, // R3
    {1'b0, 4'd3, 16'h0F00, 32'h0000_0002, 1'b1, 1'b0}, // R3
    {1'b0, 4'd4, 16'h0F00, 32'h0000_0003, 1'b0, 1'b1}, // R4
    {1'b0, 4'd5, 16'h0F00, 32'h0000_0004, 1'b0, 1'b0}, // R5
    {1'b1, 4'd5, 16'h0F00, 32'h0000_0004, 1'b0, 1'b0}, // R5
    {1'b0, 4'd5, 16'h0F00, 32'h0000_0000, 1'b0, 1'b0}, // R5
    {1'b0, 4'd6, 16'h0108, 32'h0000_0000, 1'b0, 1'b0}, // R6
    {1'b1, 4'd6, 16'h0108, 32'h3000_0000, 1'b0, 1'b0}, // R6
    {1'b0, 4'd6, 16'h0104, 32'h0000_0000, 1'b0, 1'b0}, // R6
    {1'b1, 4'd6, 16'h0104, 32'h0000_0000, 1'b0, 1'b0}, // R6
    {1'b1, 4'd8, 16'h0043, 32'hDEAD_BEEF, 1'b0, 1'b0}, // R8
    {1'b0, 4'd8, 16'h00F2, 32'h1234_5678, 1'b0, 1'b0}, // R8
    {1'b1, 4'd8, 16'h00F0, 32'h1234_5678, 1'b0, 1'b0}, // R8
    {1'b0, 4'd9, 16'h1040, 32'h0000_1111, 1'b0, 1'b0}, // R9
    {1'b1, 4'd9, 16'h0040, 32'hDEAD_BEEF, 1'b0, 1'b0}, // R9
    {1'b1, 4'd9, 16'h1040, 32'h0000_0000, 1'b0, 1'b0}, // R9
    {1'b0, 4'd9, 16'h1F00, 32'h0000_0001, 1'b0, 1'b0}, // R9
    {1'b0, 4'd2, 16'h0FFC, 32'hA5A5_A5A5, 1'b0, 1'b0}, // R2
    {1'b1, 4'd2, 16'h0FFC, 32'hA5A5_A5A5, 1'b0, 1'b0}  // R2
  };

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1; wr_en = 1'b0;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] v,
                          output logic r, output logic s);
    @(negedge clk);
    addr = a; wr_data = v; wr_en = 1'b1; rd_en = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    r = reset_req; s = shutdown_req;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic        r, s;
    rst_n = 1'b0; addr = '0; wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    check(10, "reset_req in reset", 32'(reset_req), 32'd0);
    check(10, "shutdown_req in reset", 32'(shutdown_req), 32'd0);
    check(10, "rd_data in reset", rd_data, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic        is_rd;
      logic [3:0]  rq;
      logic [15:0] va;
      logic [31:0] vd;
      logic        er, es;
      {is_rd, rq, va, vd, er, es} = VEC[i];
      if (is_rd) begin
        do_read(va, d);
        check(int'(rq), $sformatf("read %h", va), d, vd);
      end else begin
        do_write(va, vd, r, s);
        check(int'(rq), $sformatf("reset_req after write %h<=%h", va, vd), 32'(r), 32'(er));
        check(int'(rq), $sformatf("shutdown_req after write %h<=%h", va, vd), 32'(s), 32'(es));
        @(negedge clk);
        check(int'(rq), "reset_req one cycle", 32'(reset_req), 32'd0);
        check(int'(rq), "shutdown_req one cycle", 32'(shutdown_req), 32'd0);
      end
    end

    // R7: same-cycle read and write of one word returns the old value
    do_write(16'h0080, 32'h0000_0011, r, s);
    @(negedge clk);
    addr = 16'h0080; wr_data = 32'h0000_0022; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    check(7, "read during write", rd_data, 32'h0000_0011);
    do_read(16'h0080, d);
    check(7, "read after write", d, 32'h0000_0022);

    // R11: rd_data holds while no read strobe, even with address and writes moving
    do_read(16'h0040, d);
    addr = 16'h0100;
    @(negedge clk);
    check(11, "hold after addr change", rd_data, 32'hDEAD_BEEF);
    do_write(16'h0300, 32'h0BAD_F00D, r, s);
    check(11, "hold after write", rd_data, 32'hDEAD_BEEF);

    // R10: reset during a command write emits nothing and restores contents
    @(negedge clk);
    rst_n = 1'b0; addr = 16'h0F00; wr_data = 32'd1; wr_en = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(10, "reset_req while reset held", 32'(reset_req), 32'd0);
    end
    wr_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(10, "reset_req after release", 32'(reset_req), 32'd0);
    do_read(16'h0040, d);
    check(10, "word 0x040 cleared", d, 32'd0);
    do_read(16'h0108, d);
    check(10, "word 0x108 restored", d, 32'h35F3_0121);
    do_read(16'h0104, d);
    check(10, "word 0x104 restored", d, 32'h0000_0002);
    do_read(16'h0F00, d);
    check(10, "command word cleared", d, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule